// File: doc/BRIEF.md
# E1 Signaling Multiframe Alignment Monitor

This block watches the signaling time slot (slot 16) of an E1 receive stream that has already been brought into basic frame alignment. It finds the 16-frame channel-associated-signaling multiframe, keeps it, and declares it lost when the alignment word goes bad twice in a row or when the signaling slot carries nothing but zeros for two whole multiframes. While aligned it reports which frame of the multiframe the last signaling octet belonged to. It also passes on the remote multiframe alarm bit and the spare bits carried in the frame-0 octet.

The incoming stream is one octet per strobe, tagged with its slot index 0 to 31. Bit 1 of an octet is its MSB (`slot_data[7]`). While the multiframe is not aligned, the block does four things. It raises a hold output that freezes downstream signaling storage. It drives the spare control bits to all ones and the remote alarm status to zero. It requests remote multiframe alarm transmission and AIS insertion into the system-side signaling slot, and each request is passed out only when its own enable input is set.

Top module: `cas_mf_align`

## Requirements
- R1: While `frame_locked` is 0, `mf_locked` is 0 one clock after the edge that samples it. Signaling octets received while `frame_locked` is 0 are ignored and do not count as the octet preceding a candidate pattern.
- R2: When not aligned, the block locks on the first slot-16 octet whose bits 1–4 (`slot_data[7:4]`) are 0000, provided the slot-16 octet received just before it under basic alignment had at least one bit at 1. That octet becomes frame 0 (`mf_frame` = 0).
- R3: When aligned, two consecutive frame-0 words with `slot_data[7:4]` not equal to 0000 cause loss of alignment. A single errored word followed by a correct one keeps the lock.
- R4: When aligned, 32 consecutive all-zero slot-16 octets cause loss of alignment. Any octet with a 1 bit restarts that run, so 31 zeros are not enough.
- R5: `sig_hold` is 1 exactly while the multiframe is not aligned.
- R6: While not aligned, `rx_spare` is 3'b111 and `rx_mf_alarm` is 0. While aligned, both come from the last correct frame-0 word: `rx_mf_alarm` = bit 6 (`slot_data[2]`) and `rx_spare` = {bit 5, bit 7, bit 8} = {`slot_data[3]`, `slot_data[1]`, `slot_data[0]`}. An errored word leaves them unchanged.
- R7: `tx_mf_alarm_req` = not aligned AND `cfg_mf_alarm_en`. `sys_ais_req` = not aligned AND `cfg_sys_ais_en`.
- R8: While aligned, `mf_frame` advances by one on each slot-16 octet and wraps from 15 to 0. The word is checked only in the octet counted as frame 0, so nonzero bits 1–4 in other frames have no effect.
- R9: After reset the block is not aligned, with `mf_frame` = 0 and all run and error counts cleared.
- R10: Strobes for slot indices other than 16 have no effect on alignment, counting or received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Strobe: one octet present this cycle |
| slot_idx | input | 5 | Slot index of the octet (0–31) |
| slot_data | input | 8 | Octet, bit 1 at bit 7 |
| frame_locked | input | 1 | Basic frame alignment present |
| cfg_mf_alarm_en | input | 1 | Enable for the remote multiframe alarm request |
| cfg_sys_ais_en | input | 1 | Enable for the system-side AIS request |
| mf_locked | output | 1 | Multiframe alignment held |
| mf_frame | output | 4 | Frame number of the last slot-16 octet |
| sig_hold | output | 1 | Freeze signaling updates |
| rx_spare | output | 3 | Received spare control bits (forced to ones) |
| rx_mf_alarm | output | 1 | Received remote multiframe alarm (forced to 0) |
| tx_mf_alarm_req | output | 1 | Request to send remote multiframe alarm |
| sys_ais_req | output | 1 | Request to insert AIS in the system slot 16 |

## Verification
Every result of a slot-16 strobe (lock, loss, frame number and received bits) is registered, so it is due one clock after the strobe. The requests, `sig_hold` and the forced values follow the alignment state with no further delay. A drop of `frame_locked` takes effect at the next clock edge, even when no strobe is present. The bench drives each strobe at a falling edge for one cycle and holds the bus idle for the next. It samples at the falling edge after the capturing rising edge, so each check reads values that exactly one register stage has updated.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;
   typedef enum logic {
      MF_HUNT = 1'b0,
      MF_SYNC = 1'b1
   } mf_state_e;

   // Field positions inside the frame-0 signaling octet (bit 1 = MSB)
   localparam int WORD_HI  = 7;
   localparam int WORD_LO  = 4;
   localparam int SPARE_A  = 3;
   localparam int ALARM_B  = 2;
   localparam int SPARE_B  = 1;
   localparam int SPARE_C  = 0;
   localparam int SPARE_N  = 3;
endpackage

// File: rtl/cas_zero_run.sv
module cas_zero_run #(
   parameter int SPAN = 32,
   localparam int CW  = $clog2(SPAN)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic all_zero,
   output logic span_hit
);
   logic [CW-1:0] run_q;
   localparam logic [CW-1:0] LAST = CW'(SPAN - 1);

   initial begin : param_chk
      assert (SPAN >= 2) else $error("SPAN must be at least 2");
   end

   assign span_hit = step && all_zero && (run_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         run_q <= '0;
      end else if (step) begin
         if (!all_zero)         run_q <= '0;
         else if (run_q != LAST) run_q <= run_q + 1'b1;
      end
   end

   // a one in the slot always restarts the run
   assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !all_zero && !clr) |=> (run_q == '0));
endmodule

// File: rtl/cas_word_check.sv
module cas_word_check #(
   parameter int LIMIT = 2,
   localparam int CW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic check,
   input  logic word_bad,
   output logic limit_hit
);
   logic [CW-1:0] err_q;

   initial begin : param_chk
      assert (LIMIT >= 1) else $error("LIMIT must be at least 1");
   end

   assign limit_hit = check && word_bad && (err_q == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         err_q <= '0;
      end else if (check) begin
         if (!word_bad)      err_q <= '0;
         else if (!limit_hit) err_q <= err_q + 1'b1;
      end
   end

   assert_err_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_q < CW'(LIMIT));
   assert_good_word_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (check && !word_bad) |=> (err_q == '0));
endmodule

// File: rtl/cas_mf_counter.sv
module cas_mf_counter #(
   parameter int MF_LEN = 16,
   parameter int MF_W   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            advance,
   output logic [MF_W-1:0] frame,
   output logic            at_last
);
   localparam logic [MF_W-1:0] LAST = MF_W'(MF_LEN - 1);

   initial begin : param_chk
      assert (MF_LEN >= 2 && (1 << MF_W) >= MF_LEN)
         else $error("MF_W too narrow for MF_LEN");
   end

   assign at_last = (frame == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)   frame <= '0;
      else if (advance)    frame <= at_last ? '0 : frame + 1'b1;
   end

   assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clr && frame == LAST) |=> (frame == '0));
   assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clr && frame != LAST) |=> (frame == $past(frame) + 1'b1));
endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align #(
   parameter int SLOT_W    = 5,
   parameter int SIG_SLOT  = 16,
   parameter int MF_LEN    = 16,
   parameter int MF_W      = $clog2(MF_LEN),
   parameter int ZERO_SPAN = 2 * MF_LEN,
   parameter int ERR_LIMIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_valid,
   input  logic [SLOT_W-1:0] slot_idx,
   input  logic [7:0]        slot_data,
   input  logic              frame_locked,
   input  logic              cfg_mf_alarm_en,
   input  logic              cfg_sys_ais_en,
   output logic              mf_locked,
   output logic [MF_W-1:0]   mf_frame,
   output logic              sig_hold,
   output logic [2:0]        rx_spare,
   output logic              rx_mf_alarm,
   output logic              tx_mf_alarm_req,
   output logic              sys_ais_req
);
   import cas_mf_pkg::*;

   initial begin : param_chk
      assert (SIG_SLOT < (1 << SLOT_W)) else $error("SIG_SLOT out of range");
      assert (ZERO_SPAN >= 2)           else $error("ZERO_SPAN too small");
   end

   mf_state_e         state_q;
   logic              prev_one_q;
   logic              alarm_q;
   logic [SPARE_N-1:0] spare_q;

   logic sig_octet, in_sync, word_zero, hunt_hit, word_slot;
   logic err_hit, zero_hit, loss, ctr_last;

   assign sig_octet = slot_valid && frame_locked &&
                      (slot_idx == SLOT_W'(SIG_SLOT));
   assign in_sync   = (state_q == MF_SYNC);
   assign word_zero = (slot_data[WORD_HI:WORD_LO] == '0);
   assign hunt_hit  = !in_sync && sig_octet && word_zero && prev_one_q;
   assign word_slot = in_sync && sig_octet && ctr_last;
   assign loss      = in_sync && (!frame_locked || err_hit || zero_hit);

   cas_word_check #(.LIMIT(ERR_LIMIT)) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!in_sync),
      .check     (word_slot),
      .word_bad  (!word_zero),
      .limit_hit (err_hit)
   );

   logic zero_raw;
   cas_zero_run #(.SPAN(ZERO_SPAN)) u_zero (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (!frame_locked || loss),
      .step     (sig_octet),
      .all_zero (slot_data == 8'h00),
      .span_hit (zero_raw)
   );
   assign zero_hit = in_sync && zero_raw;

   cas_mf_counter #(.MF_LEN(MF_LEN), .MF_W(MF_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (loss || (!in_sync && !hunt_hit)),
      .advance (in_sync && sig_octet),
      .frame   (mf_frame),
      .at_last (ctr_last)
   );

   // alignment state and the octet that precedes a candidate pattern
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= MF_HUNT;
         prev_one_q <= 1'b0;
      end else begin
         if (hunt_hit)  state_q <= MF_SYNC;
         else if (loss) state_q <= MF_HUNT;
         if (!frame_locked)  prev_one_q <= 1'b0;
         else if (sig_octet) prev_one_q <= (slot_data != 8'h00);
      end
   end

   // received bits are taken only from words accepted as correct
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= 1'b0;
         spare_q <= '1;
      end else if (hunt_hit || (word_slot && word_zero)) begin
         alarm_q <= slot_data[ALARM_B];
         spare_q <= {slot_data[SPARE_A], slot_data[SPARE_B], slot_data[SPARE_C]};
      end
   end

   assign mf_locked       = in_sync;
   assign sig_hold        = !in_sync;
   assign rx_mf_alarm     = in_sync && alarm_q;
   assign tx_mf_alarm_req = !in_sync && cfg_mf_alarm_en;
   assign sys_ais_req     = !in_sync && cfg_sys_ais_en;

   for (genvar i = 0; i < SPARE_N; i++) begin : g_force
      assign rx_spare[i] = in_sync ? spare_q[i] : 1'b1;
   end

   assert_no_lock_without_fa_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_locked |=> !mf_locked);
   assert_lock_needs_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mf_locked && sig_octet && !prev_one_q) |=> !mf_locked);
   assert_lock_frame0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mf_locked) |-> (mf_frame == '0));
   assert_double_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_locked && err_hit) |=> !mf_locked);
   assert_zero_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mf_locked && zero_raw) |=> !mf_locked);
   assert_forced_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_locked |-> (rx_spare == 3'b111 && !rx_mf_alarm && sig_hold));
   assert_req_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mf_alarm_req || sys_ais_req) |-> !mf_locked);
   assert_idle_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!mf_locked && !$rose(mf_locked)) |-> (mf_frame == '0));
endmodule

// File: tb/sim_cas_mf_align.sv
module sim_cas_mf_align;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_valid = 1'b0;
   logic [4:0] slot_idx = '0;
   logic [7:0] slot_data = '0;
   logic       frame_locked = 1'b0;
   logic       cfg_mf_alarm_en = 1'b0;
   logic       cfg_sys_ais_en = 1'b0;
   logic       mf_locked, sig_hold, rx_mf_alarm, tx_mf_alarm_req, sys_ais_req;
   logic [3:0] mf_frame;
   logic [2:0] rx_spare;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cas_mf_align u0 (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_idx(slot_idx),
      .slot_data(slot_data), .frame_locked(frame_locked),
      .cfg_mf_alarm_en(cfg_mf_alarm_en), .cfg_sys_ais_en(cfg_sys_ais_en),
      .mf_locked(mf_locked), .mf_frame(mf_frame), .sig_hold(sig_hold),
      .rx_spare(rx_spare), .rx_mf_alarm(rx_mf_alarm),
      .tx_mf_alarm_req(tx_mf_alarm_req), .sys_ais_req(sys_ais_req));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one octet per strobe: driven at a falling edge, then one idle cycle
   task automatic put(input logic [4:0] idx, input logic [7:0] d);
      @(negedge clk);
      slot_valid = 1'b1; slot_idx = idx; slot_data = d;
      @(negedge clk);
      slot_valid = 1'b0; slot_data = 8'h00;
   endtask

   task automatic sig(input logic [7:0] d);
      put(5'd16, d);
   endtask

   task automatic fills(input int n);
      for (int i = 0; i < n; i++) sig(8'h55);
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) sig(8'h00);
   endtask

   task automatic t_reset;
      check("R9", "locked after reset", mf_locked, 0);
      check("R9", "frame after reset", mf_frame, 0);
      check("R5", "hold after reset", sig_hold, 1);
      check("R6", "spare forced", rx_spare, 3'b111);
      check("R6", "alarm forced", rx_mf_alarm, 0);
      check("R7", "requests disabled", {tx_mf_alarm_req, sys_ais_req}, 2'b00);
   endtask

   task automatic t_acquire;
      frame_locked = 1'b1;
      sig(8'h00); sig(8'h00);
      check("R2", "no lock without preceding one", mf_locked, 0);
      sig(8'h55);
      put(5'd5, 8'h00);
      check("R10", "other slot ignored", mf_locked, 0);
      sig(8'h0D);
      check("R2", "lock on 0000 after a one", mf_locked, 1);
      check("R2", "lock frame is 0", mf_frame, 0);
      check("R6", "alarm from word", rx_mf_alarm, 1);
      check("R6", "spare from word", rx_spare, 3'b101);
      check("R5", "hold released", sig_hold, 0);
   endtask

   task automatic t_counter;
      fills(15);
      check("R8", "frame reaches 15, other frames unchecked", {mf_locked, mf_frame}, 5'h1F);
      sig(8'h0D);
      check("R8", "frame wraps to 0", {mf_locked, mf_frame}, 5'h10);
   endtask

   task automatic t_single_error;
      fills(15);
      sig(8'h8D);
      check("R3", "single errored word keeps lock", mf_locked, 1);
      check("R6", "errored word leaves alarm", rx_mf_alarm, 1);
      fills(15);
      sig(8'h09);
      check("R3", "lock after good word", mf_locked, 1);
      check("R6", "alarm updated", rx_mf_alarm, 0);
      check("R6", "spare updated", rx_spare, 3'b101);
   endtask

   task automatic t_double_error;
      cfg_mf_alarm_en = 1'b1; cfg_sys_ais_en = 1'b0;
      #1;
      check("R7", "no request while aligned", {tx_mf_alarm_req, sys_ais_req}, 2'b00);
      fills(15); sig(8'hF0);
      check("R3", "first error keeps lock", mf_locked, 1);
      fills(15); sig(8'hF0);
      check("R3", "second error loses lock", mf_locked, 0);
      check("R5", "hold after loss", sig_hold, 1);
      check("R6", "forced bits after loss", {rx_spare, rx_mf_alarm}, 4'b1110);
      check("R7", "alarm request only", {tx_mf_alarm_req, sys_ais_req}, 2'b10);
      cfg_mf_alarm_en = 1'b0; cfg_sys_ais_en = 1'b1;
      #1;
      check("R7", "AIS request only", {tx_mf_alarm_req, sys_ais_req}, 2'b01);
      cfg_sys_ais_en = 1'b0;
      sig(8'h55); sig(8'h0D);
      check("R2", "reacquire", mf_locked, 1);
   endtask

   task automatic t_zero_run;
      zeros(20); sig(8'h01); zeros(31);
      check("R4", "31 zeros keep lock", mf_locked, 1);
      zeros(1);
      check("R4", "32 zeros lose lock", mf_locked, 0);
   endtask

   task automatic t_fa_loss;
      sig(8'h55); sig(8'h0D);
      check("R2", "lock before FA loss", mf_locked, 1);
      @(negedge clk); frame_locked = 1'b0;
      @(negedge clk);
      check("R1", "FA loss drops lock", mf_locked, 0);
      sig(8'h55);
      frame_locked = 1'b1;
      sig(8'h0D);
      check("R1", "octet during FA loss ignored", mf_locked, 0);
      sig(8'h55); sig(8'h0D);
      check("R1", "search after FA returns", mf_locked, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_acquire();
      t_counter();
      t_single_error();
      t_double_error();
      t_zero_run();
      t_fa_loss();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule